// File: doc/BRIEF.md
# Serial-Wire Debug Port Connect and Power-Up Sequencer

This block brings a serial-wire debug target from an unknown line state to a powered debug domain. On a start pulse it drives a raw bit-stream generator to place the target in serial-wire mode. Two connect flows are available:

- For a port that can also speak JTAG, it sends a line reset, the 16-bit mode-switch code and a second line reset.
- For a serial-wire-only port that comes up dormant, it sends a wake sequence and then a line reset.

After the connect flow it issues debug-port transfers through an external transfer engine. It optionally selects a target on a multi-drop bus, then reads and checks the identification register. It then clears sticky errors, zeroes the bank-select register and requests debug and system power. Finally it polls the control/status register until both power acknowledges are reported, up to a bounded number of reads.

The acknowledge of every transfer that carries one is checked before the next step, so a fault is attributed to the step that caused it. The result is reported as a one-cycle done pulse, together with a success flag, an error code, the step at which the run stopped and the identification value read back.

Top module: `dpc_connect`

## Requirements
- R1: After reset, busy, done, ok, line_en and xfer_req are 0 and err_code is 0.
- R2: With mode_dormant=0, the line stream is as follows. It starts with RESET_HIGH ones followed by IDLE_LOW zeros. Next come the 16 bits of SWITCH_CODE (0x79E7), most significant bit first. The stream ends with a second copy of the reset pattern.
- R3: With mode_dormant=1, the line stream is as follows. It starts with 8 ones. Next come the 128 bits of the alert value 0x19BC0EA2E3DDAFE986852D956209F392, least significant bit first. Then come 4 zeros and the 8-bit activation code 0x1A, least significant bit first. The stream ends with one reset pattern.
- R4: With multidrop=1, the first transfer is a write (xfer_rnw=0) of targetsel to address 0xC, and its acknowledge is ignored. With multidrop=0, that write is skipped.
- R5: The identification register is read at address 0x0 and the value is shown on idcode. If it differs from expect_id, the run ends with err_code=2 and err_step=6, and no further transfer is made.
- R6: After a matching identification read, three writes follow in this order: 0x1E to address 0x0, 0 to address 0x8, and 0x50000000 to address 0x4.
- R7: Address 0x4 is then read repeatedly until bits [31:28] equal 0xF. At that point done pulses with ok=1 and err_code=0.
- R8: If POLL_MAX reads of address 0x4 all show bits [31:28] other than 0xF, the run ends after exactly POLL_MAX reads with err_code=3 and err_step=10.
- R9: An acknowledge other than 3'b001 on a checked transfer ends the run with err_code=1. In that case err_step names the step, using the codes 6 (ident read), 7 (clear), 8 (bank), 9 (power request) and 10 (poll), and no further transfer is made.
- R10: done is a one-cycle pulse, once per run. A start pulse seen while busy has no effect on the run in progress.
- R11: line_en and xfer_req are never high together. A request holds its address, direction and write data until xfer_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a connect run when idle |
| mode_dormant | input | 1 | 1: wake flow for a dormant port; 0: JTAG-to-serial switch flow |
| multidrop | input | 1 | 1: write the target-select value after connect |
| targetsel | input | 32 | Target-select value for multi-drop |
| expect_id | input | 32 | Expected identification value |
| line_en | output | 1 | Raw line bit valid this cycle |
| line_bit | output | 1 | Raw line bit to drive |
| xfer_req | output | 1 | Transfer request, held until xfer_done |
| xfer_rnw | output | 1 | 1: read, 0: write |
| xfer_addr | output | 4 | Debug-port register byte address |
| xfer_wdata | output | 32 | Write data |
| xfer_done | input | 1 | Transfer finished (one cycle) |
| xfer_ack | input | 3 | Acknowledge of the finished transfer |
| xfer_rdata | input | 32 | Read data of the finished transfer |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Run succeeded |
| err_code | output | 2 | 0 none, 1 acknowledge fault, 2 identification mismatch, 3 power-up timeout |
| err_step | output | 4 | Step code at which the run stopped |
| idcode | output | 32 | Identification value read |

## Verification
The assertions rely on the transfer engine pulsing xfer_done for exactly one cycle, and only while xfer_req is high. They also rely on the engine taking the request exactly as it stood when the request began. The bench's engine model keeps to this contract: it answers a request only after the request is seen, drives done for a single cycle and then releases it. It also waits at least one cycle before watching for the next request. Its read data and acknowledge depend only on the address, on direction and on counters set per scenario, which gives the poll, fault and mismatch runs their controlled responses.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam logic [2:0]   ACK_OK     = 3'b001;
    localparam logic [127:0] ALERT_SEQ  = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;
    localparam logic [7:0]   ACT_SERIAL = 8'h1A;
    localparam int           WAKE_LEAD  = 8;
    localparam int           ALERT_LEN  = 128;
    localparam int           WAKE_GAP   = 4;
    localparam int           ACT_LEN    = 8;
    localparam int           WAKE_LEN   = WAKE_LEAD + ALERT_LEN + WAKE_GAP + ACT_LEN;
    localparam int           SWITCH_LEN = 16;

    localparam logic [3:0]   A_IDENT = 4'h0;
    localparam logic [3:0]   A_CTRL  = 4'h4;
    localparam logic [3:0]   A_BANK  = 4'h8;
    localparam logic [3:0]   A_TSEL  = 4'hC;
    localparam logic [31:0]  CLR_STICKY = 32'h0000_001E;
    localparam logic [31:0]  PWR_REQ    = 32'h5000_0000;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_LR1  = 4'd1,
        ST_SWT  = 4'd2,
        ST_LR2  = 4'd3,
        ST_WAKE = 4'd4,
        ST_TSEL = 4'd5,
        ST_RDID = 4'd6,
        ST_CLR  = 4'd7,
        ST_BANK = 4'd8,
        ST_PWR  = 4'd9,
        ST_POLL = 4'd10
    } dpc_step_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ACK     = 2'd1,
        ERR_ID      = 2'd2,
        ERR_TIMEOUT = 2'd3
    } dpc_err_e;

    typedef enum logic [1:0] {
        LN_RESET  = 2'd0,
        LN_SWITCH = 2'd1,
        LN_WAKE   = 2'd2
    } dpc_line_e;

    typedef struct packed {
        logic        valid;
        logic        rnw;
        logic [3:0]  addr;
        logic [31:0] wdata;
    } dpc_xfer_t;

    function automatic logic wake_bit(input logic [7:0] i);
        logic [7:0] k;
        if (i < 8'(WAKE_LEAD)) return 1'b1;
        k = i - 8'(WAKE_LEAD);
        if (k < 8'(ALERT_LEN)) return ALERT_SEQ[k[6:0]];
        k = k - 8'(ALERT_LEN);
        if (k < 8'(WAKE_GAP)) return 1'b0;
        k = k - 8'(WAKE_GAP);
        return ACT_SERIAL[k[2:0]];
    endfunction

    function automatic dpc_xfer_t xfer_for(input dpc_step_e s, input logic [31:0] tsel);
        dpc_xfer_t x;
        x = '{valid: 1'b0, rnw: 1'b0, addr: 4'h0, wdata: 32'h0};
        case (s)
            ST_TSEL: x = '{valid: 1'b1, rnw: 1'b0, addr: A_TSEL,  wdata: tsel};
            ST_RDID: x = '{valid: 1'b1, rnw: 1'b1, addr: A_IDENT, wdata: 32'h0};
            ST_CLR:  x = '{valid: 1'b1, rnw: 1'b0, addr: A_IDENT, wdata: CLR_STICKY};
            ST_BANK: x = '{valid: 1'b1, rnw: 1'b0, addr: A_BANK,  wdata: 32'h0};
            ST_PWR:  x = '{valid: 1'b1, rnw: 1'b0, addr: A_CTRL,  wdata: PWR_REQ};
            ST_POLL: x = '{valid: 1'b1, rnw: 1'b1, addr: A_CTRL,  wdata: 32'h0};
            default: ;
        endcase
        return x;
    endfunction

endpackage

// File: rtl/dpc_linegen.sv
module dpc_linegen
    import dpc_pkg::*;
#(
    parameter int          RESET_HIGH  = 56,
    parameter int          IDLE_LOW    = 2,
    parameter logic [15:0] SWITCH_CODE = 16'h79E7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  dpc_line_e go_op,
    output logic      line_en,
    output logic      line_bit,
    output logic      fin
);
    localparam int LR_LEN  = RESET_HIGH + IDLE_LOW;
    localparam int MAX_A   = (LR_LEN > WAKE_LEN) ? LR_LEN : WAKE_LEN;
    localparam int MAX_LEN = (MAX_A > SWITCH_LEN) ? MAX_A : SWITCH_LEN;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic          active_q;
    dpc_line_e     op_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_idx;
    logic [15:0]   sw_shift;
    logic          raw_bit;

    always_comb begin
        case (op_q)
            LN_SWITCH: last_idx = CW'(SWITCH_LEN - 1);
            LN_WAKE:   last_idx = CW'(WAKE_LEN - 1);
            default:   last_idx = CW'(LR_LEN - 1);
        endcase
    end

    assign sw_shift = SWITCH_CODE << cnt_q[3:0];

    always_comb begin
        case (op_q)
            LN_SWITCH: raw_bit = sw_shift[15];
            LN_WAKE:   raw_bit = wake_bit(cnt_q[7:0]);
            default:   raw_bit = (cnt_q < CW'(RESET_HIGH));
        endcase
    end

    assign line_en  = active_q;
    assign line_bit = active_q & raw_bit;
    assign fin      = active_q && (cnt_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            op_q     <= LN_RESET;
            cnt_q    <= '0;
        end else if (!active_q) begin
            if (go) begin
                active_q <= 1'b1;
                op_q     <= go_op;
                cnt_q    <= '0;
            end
        end else if (fin) begin
            active_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/dpc_poll_ctr.sv
module dpc_poll_ctr #(
    parameter int POLL_MAX = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

    logic [PW-1:0] cnt_q;

    assign last = (cnt_q == PW'(POLL_MAX - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (bump)  cnt_q <= cnt_q + PW'(1);
    end

endmodule

// File: rtl/dpc_connect.sv
module dpc_connect
    import dpc_pkg::*;
#(
    parameter int          RESET_HIGH  = 56,
    parameter int          IDLE_LOW    = 2,
    parameter logic [15:0] SWITCH_CODE = 16'h79E7,
    parameter int          POLL_MAX    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        mode_dormant,
    input  logic        multidrop,
    input  logic [31:0] targetsel,
    input  logic [31:0] expect_id,
    output logic        line_en,
    output logic        line_bit,
    output logic        xfer_req,
    output logic        xfer_rnw,
    output logic [3:0]  xfer_addr,
    output logic [31:0] xfer_wdata,
    input  logic        xfer_done,
    input  logic [2:0]  xfer_ack,
    input  logic [31:0] xfer_rdata,
    output logic        busy,
    output logic        done,
    output logic        ok,
    output logic [1:0]  err_code,
    output logic [3:0]  err_step,
    output logic [31:0] idcode
);
    dpc_step_e   st_q;
    dpc_step_e   line_next;
    dpc_err_e    err_q;
    dpc_step_e   err_step_q;
    dpc_line_e   line_op;
    dpc_xfer_t   xd;
    logic        issued_q, md_q, done_q, ok_q;
    logic [31:0] tsel_q, exp_q, id_q;
    logic        line_state, line_go, line_fin;
    logic        ack_good, pwr_up, poll_clr, poll_bump, poll_last;

    assign line_state = (st_q == ST_LR1) || (st_q == ST_SWT) ||
                        (st_q == ST_LR2) || (st_q == ST_WAKE);
    assign line_go    = line_state && !issued_q;

    always_comb begin
        case (st_q)
            ST_SWT:  begin line_op = LN_SWITCH; line_next = ST_LR2; end
            ST_WAKE: begin line_op = LN_WAKE;   line_next = ST_LR2; end
            ST_LR1:  begin line_op = LN_RESET;  line_next = ST_SWT; end
            default: begin line_op = LN_RESET;  line_next = md_q ? ST_TSEL : ST_RDID; end
        endcase
    end

    dpc_linegen #(
        .RESET_HIGH (RESET_HIGH),
        .IDLE_LOW   (IDLE_LOW),
        .SWITCH_CODE(SWITCH_CODE)
    ) u_line (
        .clk     (clk),
        .rst     (rst),
        .go      (line_go),
        .go_op   (line_op),
        .line_en (line_en),
        .line_bit(line_bit),
        .fin     (line_fin)
    );

    assign xd         = xfer_for(st_q, tsel_q);
    assign xfer_req   = xd.valid;
    assign xfer_rnw   = xd.rnw;
    assign xfer_addr  = xd.addr;
    assign xfer_wdata = xd.wdata;

    assign ack_good  = (xfer_ack == ACK_OK);
    assign pwr_up    = (xfer_rdata[31:28] == 4'hF);
    assign poll_clr  = (st_q == ST_PWR) && xfer_done && ack_good;
    assign poll_bump = (st_q == ST_POLL) && xfer_done && ack_good && !pwr_up;

    dpc_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk (clk),
        .rst (rst),
        .clr (poll_clr),
        .bump(poll_bump),
        .last(poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            issued_q   <= 1'b0;
            md_q       <= 1'b0;
            tsel_q     <= '0;
            exp_q      <= '0;
            id_q       <= '0;
            done_q     <= 1'b0;
            ok_q       <= 1'b0;
            err_q      <= ERR_NONE;
            err_step_q <= ST_IDLE;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start) begin
                    md_q       <= multidrop;
                    tsel_q     <= targetsel;
                    exp_q      <= expect_id;
                    id_q       <= '0;
                    ok_q       <= 1'b0;
                    err_q      <= ERR_NONE;
                    err_step_q <= ST_IDLE;
                    issued_q   <= 1'b0;
                    st_q       <= mode_dormant ? ST_WAKE : ST_LR1;
                end
                ST_LR1, ST_SWT, ST_LR2, ST_WAKE: begin
                    if (line_go) issued_q <= 1'b1;
                    if (line_fin) begin
                        issued_q <= 1'b0;
                        st_q     <= line_next;
                    end
                end
                ST_TSEL: if (xfer_done) st_q <= ST_RDID;
                ST_RDID: if (xfer_done) begin
                    if (!ack_good) begin
                        err_q <= ERR_ACK; err_step_q <= st_q; done_q <= 1'b1; st_q <= ST_IDLE;
                    end else begin
                        id_q <= xfer_rdata;
                        if (xfer_rdata != exp_q) begin
                            err_q <= ERR_ID; err_step_q <= st_q; done_q <= 1'b1; st_q <= ST_IDLE;
                        end else begin
                            st_q <= ST_CLR;
                        end
                    end
                end
                ST_CLR, ST_BANK, ST_PWR: if (xfer_done) begin
                    if (!ack_good) begin
                        err_q <= ERR_ACK; err_step_q <= st_q; done_q <= 1'b1; st_q <= ST_IDLE;
                    end else if (st_q == ST_CLR) begin
                        st_q <= ST_BANK;
                    end else if (st_q == ST_BANK) begin
                        st_q <= ST_PWR;
                    end else begin
                        st_q <= ST_POLL;
                    end
                end
                ST_POLL: if (xfer_done) begin
                    if (!ack_good) begin
                        err_q <= ERR_ACK; err_step_q <= st_q; done_q <= 1'b1; st_q <= ST_IDLE;
                    end else if (pwr_up) begin
                        ok_q <= 1'b1; done_q <= 1'b1; st_q <= ST_IDLE;
                    end else if (poll_last) begin
                        err_q <= ERR_TIMEOUT; err_step_q <= st_q; done_q <= 1'b1; st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign ok       = ok_q;
    assign err_code = err_q;
    assign err_step = err_step_q;
    assign idcode   = id_q;

endmodule

// File: rtl/dpc_connect_chk.sv
module dpc_connect_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        ok,
    input logic [1:0]  err_code,
    input logic [3:0]  err_step,
    input logic        line_en,
    input logic        xfer_req,
    input logic        xfer_done,
    input logic        xfer_rnw,
    input logic [3:0]  xfer_addr,
    input logic [31:0] xfer_wdata
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !line_en && !xfer_req && !ok && err_code == 2'd0));

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        !(line_en && xfer_req));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) &&
                                      $stable(xfer_rnw) && $stable(xfer_wdata)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_ok_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (done && ok) |-> (err_code == 2'd0));

    assert_timeout_step_R8: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 2'd3) |-> (err_step == 4'd10 && !ok));

    assert_fault_stops_R9: assert property (@(posedge clk) disable iff (rst)
        (done && err_code == 2'd1) |-> (!xfer_req && !ok));

endmodule

bind dpc_connect dpc_connect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .ok        (ok),
    .err_code  (err_code),
    .err_step  (err_step),
    .line_en   (line_en),
    .xfer_req  (xfer_req),
    .xfer_done (xfer_done),
    .xfer_rnw  (xfer_rnw),
    .xfer_addr (xfer_addr),
    .xfer_wdata(xfer_wdata)
);

// File: tb/sim_dpc_connect.sv
`timescale 1ns/1ps
module sim_dpc_connect;
    localparam int          RH = 52;
    localparam int          IL = 2;
    localparam logic [15:0] SW = 16'h79E7;
    localparam int          PM = 5;
    localparam logic [127:0] ALERT = 128'h19BC0EA2_E3DDAFE9_86852D95_6209F392;
    localparam logic [31:0] GOOD_ID = 32'h0BC1_1477;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode_dormant = 1'b0, multidrop = 1'b0;
    logic [31:0] targetsel = '0, expect_id = '0;
    logic line_en, line_bit, xfer_req, xfer_rnw, busy, done, ok;
    logic [3:0] xfer_addr, err_step;
    logic [31:0] xfer_wdata, idcode;
    logic xfer_done;
    logic [2:0] xfer_ack;
    logic [31:0] xfer_rdata;
    logic [1:0] err_code;

    always #2 clk = ~clk;

    dpc_connect #(.RESET_HIGH(RH), .IDLE_LOW(IL), .SWITCH_CODE(SW), .POLL_MAX(PM)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode_dormant(mode_dormant),
        .multidrop(multidrop), .targetsel(targetsel), .expect_id(expect_id),
        .line_en(line_en), .line_bit(line_bit), .xfer_req(xfer_req),
        .xfer_rnw(xfer_rnw), .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
        .xfer_done(xfer_done), .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata),
        .busy(busy), .done(done), .ok(ok), .err_code(err_code),
        .err_step(err_step), .idcode(idcode));

    int tests = 0, fails = 0;
    bit lbits [0:4095];
    int lcnt = 0, done_cnt = 0, overlap = 0;
    logic [3:0]  la [0:255];
    logic        lr [0:255];
    logic [31:0] lw [0:255];
    int xcnt, poll_reads;
    logic [31:0] id_val = GOOD_ID;
    int pwr_ready_at = 0, fail_at = -1;
    bit eb [0:511];
    int ecnt = 0;
    int lbase, xbase, pbase;

    always @(negedge clk) begin
        if (line_en && lcnt < 4096) begin lbits[lcnt] = line_bit; lcnt++; end
        if (done) done_cnt++;
        if (line_en && xfer_req) overlap++;
    end

    initial begin
        xfer_done = 1'b0; xfer_ack = 3'b000; xfer_rdata = '0; xcnt = 0; poll_reads = 0;
        forever begin
            @(negedge clk);
            if (xfer_req && !rst) begin
                @(negedge clk); @(negedge clk);
                if (xcnt < 256) begin la[xcnt] = xfer_addr; lr[xcnt] = xfer_rnw; lw[xcnt] = xfer_wdata; end
                xfer_rdata = 32'h0;
                if (xfer_rnw && xfer_addr == 4'h0) xfer_rdata = id_val;
                if (xfer_rnw && xfer_addr == 4'h4) begin
                    poll_reads++;
                    xfer_rdata = (poll_reads > pwr_ready_at) ? 32'hF000_0001 : 32'h0;
                end
                if (!xfer_rnw && xfer_addr == 4'hC) xfer_ack = 3'b111;
                else if (xcnt == fail_at)           xfer_ack = 3'b100;
                else                                xfer_ack = 3'b001;
                xcnt++;
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end
        end
    end

    task automatic chk(input bit cond, input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic add_bit(input bit b);
        eb[ecnt] = b; ecnt++;
    endtask

    task automatic exp_reset();
        for (int i = 0; i < RH; i++) add_bit(1'b1);
        for (int i = 0; i < IL; i++) add_bit(1'b0);
    endtask

    task automatic chk_line(input string rq);
        int bad = 0;
        chk(lcnt - lbase == ecnt, rq, lcnt - lbase, ecnt);
        for (int i = 0; i < ecnt; i++) if (lbits[lbase + i] != eb[i]) bad++;
        chk(bad == 0, rq, bad, 0);
    endtask

    task automatic run(input bit md_mode, input bit mdrop, input logic [31:0] ts, input logic [31:0] ex);
        mode_dormant = md_mode; multidrop = mdrop; targetsel = ts; expect_id = ex;
        lbase = lcnt; xbase = xcnt; pbase = poll_reads;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        do @(negedge clk); while (!done);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !ok, "R1 busy/done/ok", {busy, done, ok}, 0);
        chk(!line_en && !xfer_req, "R1 line/xfer idle", {line_en, xfer_req}, 0);
        chk(err_code == 2'd0, "R1 err_code", err_code, 0);
    endtask

    task automatic t_switch_flow();
        int d0 = done_cnt;
        ecnt = 0; exp_reset();
        for (int i = 15; i >= 0; i--) add_bit(SW[i]);
        exp_reset();
        id_val = GOOD_ID; pwr_ready_at = poll_reads + 2; fail_at = -1;
        run(1'b0, 1'b0, 32'h0, GOOD_ID);
        chk_line("R2 switch line stream");
        chk(xcnt - xbase == 7, "R6 transfer count", xcnt - xbase, 7);
        chk(la[xbase] == 4'h0 && lr[xbase], "R4 R5 first is ident read", la[xbase], 0);
        chk(la[xbase+1] == 4'h0 && !lr[xbase+1] && lw[xbase+1] == 32'h1E, "R6 clear write", lw[xbase+1], 32'h1E);
        chk(la[xbase+2] == 4'h8 && !lr[xbase+2] && lw[xbase+2] == 32'h0, "R6 bank write", la[xbase+2], 8);
        chk(la[xbase+3] == 4'h4 && !lr[xbase+3] && lw[xbase+3] == 32'h5000_0000, "R6 power write", lw[xbase+3], 32'h5000_0000);
        chk(poll_reads - pbase == 3, "R7 poll reads", poll_reads - pbase, 3);
        chk(ok && err_code == 2'd0, "R7 success", {ok, err_code}, 3'b100);
        chk(idcode == GOOD_ID, "R5 idcode", idcode, GOOD_ID);
        @(negedge clk);
        chk(!done && done_cnt - d0 == 1, "R10 single done pulse", done_cnt - d0, 1);
    endtask

    task automatic t_wake_multidrop();
        ecnt = 0;
        for (int i = 0; i < 8; i++) add_bit(1'b1);
        for (int i = 0; i < 128; i++) add_bit(ALERT[i]);
        for (int i = 0; i < 4; i++) add_bit(1'b0);
        for (int i = 0; i < 8; i++) add_bit(8'h1A >> i);
        exp_reset();
        id_val = GOOD_ID; pwr_ready_at = poll_reads; fail_at = -1;
        run(1'b1, 1'b1, 32'h0100_2927, GOOD_ID);
        chk_line("R3 wake line stream");
        chk(la[xbase] == 4'hC && !lr[xbase] && lw[xbase] == 32'h0100_2927, "R4 target select write", lw[xbase], 32'h0100_2927);
        chk(la[xbase+1] == 4'h0 && lr[xbase+1], "R4 ack ignored, ident follows", la[xbase+1], 0);
        chk(ok && xcnt - xbase == 6, "R4 run succeeds", xcnt - xbase, 6);
    endtask

    task automatic t_id_mismatch();
        id_val = 32'h1234_5678; fail_at = -1;
        run(1'b0, 1'b0, 32'h0, GOOD_ID);
        chk(err_code == 2'd2 && err_step == 4'd6 && !ok, "R5 mismatch code/step", {err_code, err_step}, {2'd2, 4'd6});
        chk(idcode == 32'h1234_5678, "R5 idcode on mismatch", idcode, 32'h1234_5678);
        repeat (10) @(negedge clk);
        chk(xcnt - xbase == 1, "R5 no further transfers", xcnt - xbase, 1);
        id_val = GOOD_ID;
    endtask

    task automatic t_timeout();
        pwr_ready_at = poll_reads + 1000; fail_at = -1;
        run(1'b0, 1'b0, 32'h0, GOOD_ID);
        chk(err_code == 2'd3 && err_step == 4'd10, "R8 timeout code/step", {err_code, err_step}, {2'd3, 4'd10});
        repeat (10) @(negedge clk);
        chk(poll_reads - pbase == PM, "R8 poll count", poll_reads - pbase, PM);
        chk(xcnt - xbase == 4 + PM, "R8 transfer count", xcnt - xbase, 4 + PM);
    endtask

    task automatic t_ack_fault();
        pwr_ready_at = poll_reads; fail_at = xcnt + 2;
        run(1'b0, 1'b0, 32'h0, GOOD_ID);
        chk(err_code == 2'd1 && err_step == 4'd8 && !ok, "R9 fault at bank step", {err_code, err_step}, {2'd1, 4'd8});
        repeat (10) @(negedge clk);
        chk(xcnt - xbase == 3, "R9 stops after fault", xcnt - xbase, 3);
        fail_at = -1;
    endtask

    task automatic t_start_while_busy();
        int d0;
        d0 = done_cnt;
        pwr_ready_at = poll_reads; fail_at = -1;
        mode_dormant = 1'b0; multidrop = 1'b0; expect_id = GOOD_ID;
        lbase = lcnt; xbase = xcnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        mode_dormant = 1'b1; multidrop = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        do @(negedge clk); while (!done);
        repeat (30) @(negedge clk);
        chk(!busy && done_cnt - d0 == 1, "R10 start while busy ignored", done_cnt - d0, 1);
        chk(lcnt - lbase == 2*(RH+IL) + 16 && xcnt - xbase == 5, "R10 flow unchanged", lcnt - lbase, 2*(RH+IL) + 16);
        chk(ok, "R10 run completes", ok, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_switch_flow();
        t_wake_multidrop();
        t_id_mismatch();
        t_timeout();
        t_ack_fault();
        t_start_while_busy();
        chk(overlap == 0, "R11 line and transfer exclusive", overlap, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule